// File: doc/BRIEF.md
# Power-down hold wrapper

This block sits between a device's pins and its internal logic. It gives the device a power-down function that a dedicated pin controls. When a configuration bit enables the feature and that pin is high, the block freezes three things. The inputs seen by the core stay fixed. The values the outputs drive stay fixed. The enables of the outputs stay fixed. A hold indication goes to the core so that its own state registers can freeze at the same time. Any activity on the pins is ignored until the power-down pin goes low again.

The power-down pin is sampled on the clock, so entry and exit each take effect at a clock edge. The values that are held are the ones present at the entry edge. When the feature is disabled, the block passes every signal straight through and the power-down pin is an ordinary input to the core. When the feature is enabled, the core sees that pin as a constant low.

Top module: `pd_hold_wrap`

## Requirements
- R1: While reset is asserted and in the first cycle after it, core_hold is 0. core_in equals pin_in, pin_out equals core_out and pin_oe equals core_oe.
- R2: With pd_feature_en at 0, core_hold stays 0 whatever pd_pin does. All data and enable paths pass through in the same cycle.
- R3: With pd_feature_en at 0, pd_to_core equals pd_pin.
- R4: With pd_feature_en at 1, pd_to_core reads 0 whatever the level of pd_pin.
- R5: A clock edge that samples pd_feature_en and pd_pin both at 1, while not yet holding, sets core_hold to 1. From that edge on, core_in shows the pin_in value present at that edge.
- R6: While core_hold is 1, changes on pin_in do not reach core_in.
- R7: While core_hold is 1, pin_out and pin_oe keep the values that were captured at the entry edge, and changes on core_out and core_oe do not reach them. A captured enable of 0 therefore keeps that output at high impedance.
- R8: The first clock edge that samples pd_pin low, or pd_feature_en low, clears core_hold. After that edge every path passes the current values through again.
- R9: Holding across several cycles with varied pin activity, and then re-entering right after a release, both capture the values present at the newest entry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_feature_en | input | 1 | Configuration bit that turns on the power-down feature |
| pd_pin | input | 1 | Power-down pin, active high |
| pin_in | input | NIN | Raw values from the input pins |
| core_out | input | NOUT | Output data from the core logic |
| core_oe | input | NOUT | Output enables from the core logic, 1 means drive |
| core_in | output | NIN | Input values delivered to the core, held during power-down |
| pd_to_core | output | 1 | Power-down pin seen as a logic input, 0 when the feature is enabled |
| core_hold | output | 1 | High while power-down is in effect; the core freezes its state |
| pin_out | output | NOUT | Output data to the pins, held during power-down |
| pin_oe | output | NOUT | Output enables to the pins, held during power-down |

## Verification
The bench drives random pin and core patterns with the feature off. With the pin high, this shows that the feature bit gates power-down, and it shows that the pin reaches the core as an input. With the feature on, the entry edge captures one pattern, and the bench then changes pin_in, core_out and core_oe on every cycle. This separates a true hold from a register that keeps tracking its input, and it includes captured enables of zero. The bench tests release in two ways, through the pin and through the feature bit, and it then re-enters at once. This shows that the new capture takes the values at the newest edge, not stale ones.

// File: rtl/pd_hold_wrap.sv
module pd_hold_wrap #(
  parameter int NIN  = 8,
  parameter int NOUT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_feature_en,
  input  logic            pd_pin,
  input  logic [NIN-1:0]  pin_in,
  input  logic [NOUT-1:0] core_out,
  input  logic [NOUT-1:0] core_oe,
  output logic [NIN-1:0]  core_in,
  output logic            pd_to_core,
  output logic            core_hold,
  output logic [NOUT-1:0] pin_out,
  output logic [NOUT-1:0] pin_oe
);

  logic            pd_req;
  logic            hold_q;
  logic [NIN-1:0]  in_snap;
  logic [NOUT-1:0] out_snap;
  logic [NOUT-1:0] oe_snap;

  assign pd_req = pd_feature_en & pd_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      in_snap  <= '0;
      out_snap <= '0;
      oe_snap  <= '0;
    end else begin
      hold_q <= pd_req;
      if (!hold_q) begin
        in_snap  <= pin_in;
        out_snap <= core_out;
        oe_snap  <= core_oe;
      end
    end
  end

  assign core_hold  = hold_q;
  assign core_in    = hold_q ? in_snap  : pin_in;
  assign pin_out    = hold_q ? out_snap : core_out;
  assign pin_oe     = hold_q ? oe_snap  : core_oe;
  assign pd_to_core = pd_feature_en ? 1'b0 : pd_pin;

endmodule

module pd_hold_wrap_chk #(
  parameter int NIN  = 8,
  parameter int NOUT = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_feature_en,
  input logic            pd_pin,
  input logic [NIN-1:0]  pin_in,
  input logic [NIN-1:0]  core_in,
  input logic            core_hold,
  input logic [NOUT-1:0] pin_out,
  input logic [NOUT-1:0] pin_oe
);

  assert_disabled_no_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_feature_en |=> !core_hold);

  assert_entry_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_feature_en && pd_pin && !core_hold) |=> (core_hold && core_in == $past(pin_in)));

  assert_inputs_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && pd_feature_en && pd_pin) |=> $stable(core_in));

  assert_outputs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && pd_feature_en && pd_pin) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_feature_en && pd_pin) |=> !core_hold);

endmodule

bind pd_hold_wrap pd_hold_wrap_chk #(.NIN(NIN), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_feature_en(pd_feature_en), .pd_pin(pd_pin),
  .pin_in(pin_in), .core_in(core_in), .core_hold(core_hold),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_pd_hold_wrap.sv
module test_pd_hold_wrap;
  localparam int NIN  = 8;
  localparam int NOUT = 8;

  typedef struct packed {
    logic [NIN-1:0]  ci;
    logic            pdc;
    logic            h;
    logic [NOUT-1:0] po;
    logic [NOUT-1:0] oe;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_feature_en = 1'b0;
  logic pd_pin = 1'b0;
  logic [NIN-1:0]  pin_in = '0;
  logic [NOUT-1:0] core_out = '0;
  logic [NOUT-1:0] core_oe = '0;
  logic [NIN-1:0]  core_in;
  logic            pd_to_core;
  logic            core_hold;
  logic [NOUT-1:0] pin_out;
  logic [NOUT-1:0] pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  item_t exp_q[$];
  string tag_q[$];

  logic            m_hold = 1'b0;
  logic [NIN-1:0]  m_in = '0;
  logic [NOUT-1:0] m_out = '0;
  logic [NOUT-1:0] m_oe = '0;

  always #4 clk = ~clk;

  pd_hold_wrap #(.NIN(NIN), .NOUT(NOUT)) i_pd_hold_wrap (
    .clk(clk), .rst_n(rst_n), .pd_feature_en(pd_feature_en), .pd_pin(pd_pin),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pd_to_core(pd_to_core), .core_hold(core_hold),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic drive(input logic rst, input logic en, input logic pd,
                       input logic [NIN-1:0] pi, input logic [NOUT-1:0] co,
                       input logic [NOUT-1:0] oe, input string tag);
    item_t e;
    @(negedge clk);
    rst_n = rst; pd_feature_en = en; pd_pin = pd;
    pin_in = pi; core_out = co; core_oe = oe;
    if (!rst) begin
      m_hold = 1'b0; m_in = '0; m_out = '0; m_oe = '0;
    end else begin
      if (!m_hold) begin m_in = pi; m_out = co; m_oe = oe; end
      m_hold = en & pd;
    end
    e.h   = m_hold;
    e.ci  = m_hold ? m_in  : pi;
    e.po  = m_hold ? m_out : co;
    e.oe  = m_hold ? m_oe  : oe;
    e.pdc = en ? 1'b0 : pd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      item_t e;
      item_t a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.ci = core_in; a.pdc = pd_to_core; a.h = core_hold; a.po = pin_out; a.oe = pin_oe;
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got ci=%h pd=%b h=%b po=%h oe=%h, expected ci=%h pd=%b h=%b po=%h oe=%h",
                 t, a.ci, a.pdc, a.h, a.po, a.oe, e.ci, e.pdc, e.h, e.po, e.oe);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    drive(0, 1, 1, 8'hA5, 8'h3C, 8'hF0, "R1 reset");
    drive(0, 1, 1, 8'h5A, 8'hC3, 8'h0F, "R1 reset");
    drive(1, 0, 0, 8'h11, 8'h22, 8'h33, "R1 first cycle");
    for (int i = 0; i < 8; i++)
      drive(1, 0, i[0], 8'($urandom), 8'($urandom), 8'($urandom), "R2 R3 disabled pass");
    for (int i = 0; i < 4; i++)
      drive(1, 1, 0, 8'($urandom), 8'($urandom), 8'($urandom), "R4 enabled idle");
    drive(1, 1, 1, 8'h96, 8'h69, 8'b1010_0101, "R5 entry");
    for (int i = 0; i < 6; i++)
      drive(1, 1, 1, 8'($urandom), 8'($urandom), 8'($urandom), "R6 R7 held");
    drive(1, 1, 0, 8'h01, 8'h02, 8'h04, "R8 release by pin");
    drive(1, 1, 0, 8'h81, 8'h42, 8'h24, "R8 pass after release");
    drive(1, 1, 1, 8'hE7, 8'h7E, 8'h00, "R9 re-entry oe off");
    drive(1, 1, 1, 8'hFF, 8'hFF, 8'hFF, "R7 highz kept");
    drive(1, 1, 0, 8'h10, 8'h20, 8'h40, "R8 release");
    drive(1, 1, 1, 8'h3A, 8'hA3, 8'h5C, "R9 immediate re-entry");
    drive(1, 1, 1, 8'h00, 8'h00, 8'h00, "R6 held");
    drive(1, 0, 1, 8'hC8, 8'h8C, 8'hAA, "R8 release by feature bit");
    drive(1, 0, 1, 8'h19, 8'h91, 8'h55, "R2 R3 disabled pd high");
    drive(1, 0, 0, 8'h00, 8'h00, 8'h00, "R2 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule